// File: doc/BRIEF.md
# Latched Interrupt Source Controller

This block gathers up to six single-bit event inputs into a sticky status register and drives one interrupt line towards the host. Each input is synchronized, and only a low-to-high transition on an input whose enable bit is set marks its status bit. Once set, a status bit stays set until the host turns that source's enable off. There is no separate acknowledge or clear register.

The host sees a single byte-wide register. A write loads the per-source enable mask. The read port returns the latched status bits at all times, so reading has no side effects. A parameter selects one of two interrupt styles. In level style the line stays high for as long as any status bit is set. In pulse style the line gives a single one-cycle pulse each time the status register goes from all zero to non-zero.

A typical handler reads the status, writes a mask with the serviced bits cleared, and then writes the full mask back to re-arm those sources.

Top module: `irq_latch_ctrl`

## Requirements
- R1: Input `src_in[i]` maps to status bit i, which is returned on `host_rdata[i]`, for i from 0 to 5.
- R2: While enable bit i is set, a rising edge on `src_in[i]` sets status bit i, and the bit stays set after the input falls. An input that is already high when its enable is written sets nothing.
- R3: A rising edge on a source whose enable bit is clear leaves the status register and the interrupt output unchanged.
- R4: Writing a mask with bit i clear clears status bit i, and `host_rdata` shows the cleared bit one cycle after the write cycle. Status bits whose enable stays set are unaffected. No other action clears status.
- R5: A write (`host_we` high for one cycle) loads `host_wdata[5:0]` as the enable mask. `host_wdata[7:6]` has no effect, and `host_rdata[7:6]` always reads zero.
- R6: A source rising edge shows on `host_rdata` and on the level-style interrupt output four clock edges after the input changes: two synchronizer stages, the status latch, and the output register.
- R7: In level style, `irq_out` is high exactly while the returned status is non-zero.
- R8: In pulse style, `irq_out` is high for one cycle when the status goes from zero to non-zero. No further pulse occurs while the status stays non-zero, and a new pulse can occur after the status has returned to zero.
- R9: A rising edge that reaches the status latch in the same cycle as a write clearing that source's enable is dropped. Re-enabling the source later does not recover the dropped edge.
- R10: After synchronous reset all enables are clear, the status reads 0x00 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 6 | Interrupt source signals |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | 8 | Enable mask to load |
| host_rdata | output | 8 | Latched status; upper two bits read zero |
| irq_out | output | 1 | Interrupt to the host, level or pulse style |

## Verification
Two instances, one of each interrupt style, are driven with the same stimulus:
- **Edge on a disabled source.** This separates edge capture from the enable gating.
- **Source already high when its enable is written.** This shows whether the design detects edges or levels.
- **Source that falls after being latched.** This confirms the status bit is sticky.
- **Second source rising while status is already non-zero.** This distinguishes the level output from the pulse output, since only the level line stays high.
- **Partial and full mask clears.** These show that only the disabled bits drop and that the interrupt follows the status back to zero.
- **Edge colliding with a clearing write.** This checks that the colliding edge is dropped and that re-enabling the source does not bring it back.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_style_e;
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] rise
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] pipe;
    logic                   prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '0;
        prev <= 1'b0;
      end else begin
        pipe <= {pipe[TOP-1:0], src_in[g]};
        prev <= pipe[TOP];
      end
    end

    assign rise[g] = pipe[TOP] & ~prev;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] mask_in,
  input  logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] enable_eff;

  // The mask in force after this cycle gates both retention and capture,
  // so an edge meeting a clearing write is lost.
  assign enable_eff = we ? mask_in : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      status   <= '0;
    end else begin
      enable_q <= enable_eff;
      status   <= (status | rise) & enable_eff;
    end
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_latch_pkg::*;
#(
  parameter int         NUM_SRC   = 6,
  parameter irq_style_e IRQ_STYLE = IRQ_LEVEL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status,
  output logic               irq
);
  logic any_set;
  assign any_set = |status;

  if (IRQ_STYLE == IRQ_PULSE) begin : g_pulse
    logic any_d;
    always_ff @(posedge clk) begin
      if (rst) begin
        any_d <= 1'b0;
        irq   <= 1'b0;
      end else begin
        any_d <= any_set;
        irq   <= any_set & ~any_d;
      end
    end
  end else begin : g_level
    always_ff @(posedge clk) begin
      if (rst) irq <= 1'b0;
      else     irq <= any_set;
    end
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int         NUM_SRC     = 6,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter irq_style_e IRQ_STYLE   = IRQ_LEVEL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               host_we,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               irq_out
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] status;

  if (PAD_W > 0) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^host_wdata[DATA_W-1:NUM_SRC];
  end

  irq_src_edge #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .src_in(src_in), .rise(rise)
  );

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst(rst), .we(host_we),
    .mask_in(host_wdata[NUM_SRC-1:0]), .rise(rise), .status(status)
  );

  irq_out_gen #(.NUM_SRC(NUM_SRC), .IRQ_STYLE(IRQ_STYLE)) u_irq (
    .clk(clk), .rst(rst), .status(status), .irq(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= DATA_W'(status);
  end
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int         NUM_SRC   = 6,
  parameter int         DATA_W    = 8,
  parameter irq_style_e IRQ_STYLE = IRQ_LEVEL
) (
  input logic               clk,
  input logic               rst,
  input logic               host_we,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               irq_out
);
  logic [NUM_SRC-1:0] st;
  assign st = host_rdata[NUM_SRC-1:0];

  // R5: bits above the sources always read zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rdata >> NUM_SRC) == '0);

  // R4: a write clears every bit it leaves disabled
  p_clear_by_mask_r4: assert property (@(posedge clk) disable iff (rst)
    host_we |=> ##1 ((st & ~$past(host_wdata[NUM_SRC-1:0], 2)) == '0));

  // R2, R4: without a write, no status bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(host_we, 2) |-> (($past(st) & ~st) == '0));

  if (IRQ_STYLE == IRQ_PULSE) begin : g_pulse
    // R8: the pulse lasts one cycle
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
      irq_out |=> !irq_out);
    // R8: a pulse only on a zero to non-zero change
    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> ((st != '0) && ($past(st) == '0)));
    // R8: every zero to non-zero change gives a pulse
    p_pulse_fires_r8: assert property (@(posedge clk) disable iff (rst)
      ((st != '0) && ($past(st) == '0)) |-> irq_out);
  end else begin : g_level
    // R7: the level follows the returned status
    p_level_track_r7: assert property (@(posedge clk) disable iff (rst)
      irq_out == (st != '0));
  end
endmodule

bind irq_latch_ctrl irq_latch_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IRQ_STYLE(IRQ_STYLE)
) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .irq_out(irq_out)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  import irq_latch_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] src_in = '0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] rdata_lvl, rdata_pls;
  logic       irq_lvl, irq_pls;

  always #5 clk = ~clk;

  irq_latch_ctrl #(.IRQ_STYLE(IRQ_LEVEL)) u_dut (
    .clk(clk), .rst(rst), .src_in(src_in), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(rdata_lvl), .irq_out(irq_lvl)
  );

  irq_latch_ctrl #(.IRQ_STYLE(IRQ_PULSE)) u_dut_edge (
    .clk(clk), .rst(rst), .src_in(src_in), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(rdata_pls), .irq_out(irq_pls)
  );

  typedef struct {
    logic [7:0] rd;
    logic       lvl;
    logic       pls;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    host_we    = 1'b1;
    host_wdata = v;
    step(1);
    host_we    = 1'b0;
  endtask

  task automatic expect_out(input logic [7:0] rd, input logic lvl,
                            input logic pls, input string tag);
    exp_t e;
    e.rd = rd; e.lvl = lvl; e.pls = pls; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each queued expectation at the next falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (rdata_lvl !== e.rd || rdata_pls !== e.rd ||
            irq_lvl !== e.lvl || irq_pls !== e.pls) begin
          n_fail++;
          $display("FAIL %s: rd=%h/%h lvl=%b pls=%b expected rd=%h lvl=%b pls=%b",
                   e.tag, rdata_lvl, rdata_pls, irq_lvl, irq_pls,
                   e.rd, e.lvl, e.pls);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    expect_out(8'h00, 0, 0, "R10 reset state"); step(1);

    // R3: edge on a disabled source
    src_in = 6'b000001; step(6);
    expect_out(8'h00, 0, 0, "R3 disabled edge ignored"); step(1);
    src_in = '0; step(4);

    // R2: source already high when enabled sets nothing
    src_in = 6'b000010; step(5);
    wr(8'h03); step(3);
    expect_out(8'h00, 0, 0, "R2 high level at enable"); step(1);

    // R6 latency, R2 capture, R8 single pulse
    src_in = 6'b000011; step(3);
    expect_out(8'h00, 0, 0, "R6 not yet after three edges"); step(1);
    expect_out(8'h01, 1, 1, "R6 R2 R8 captured on fourth edge"); step(1);
    expect_out(8'h01, 1, 0, "R8 pulse one cycle wide"); step(1);
    src_in = 6'b000010; step(5);
    expect_out(8'h01, 1, 0, "R2 sticky after fall"); step(1);

    // R8/R7: second source while non-zero
    src_in = 6'b000000; step(4);
    src_in = 6'b000010; step(5);
    expect_out(8'h03, 1, 0, "R7 R8 second source no new pulse"); step(1);

    // R4: partial then full clear
    wr(8'h02); step(1);
    expect_out(8'h02, 1, 0, "R4 partial clear"); step(1);
    wr(8'h00); step(1);
    expect_out(8'h00, 0, 0, "R4 R7 full clear"); step(1);
    src_in = '0; step(4);

    // R8: pulse again after status returned to zero
    wr(8'h3F);
    src_in = 6'b100000; step(4);
    expect_out(8'h20, 1, 1, "R8 R1 pulse after re-arm"); step(1);
    expect_out(8'h20, 1, 0, "R8 pulse ends"); step(1);

    // R5: upper write bits ignored, upper read bits zero
    src_in = '0; step(4);
    wr(8'h00); wr(8'hFF);
    src_in = 6'b111111; step(4);
    expect_out(8'h3F, 1, 1, "R5 R1 all sources, pad reads zero"); step(1);

    // R9: edge colliding with a clearing write
    wr(8'h00); wr(8'h3F);
    src_in = '0; step(4);
    expect_out(8'h00, 0, 0, "R4 cleared before collision"); step(1);
    src_in = 6'b000100; step(2);
    wr(8'h3B); step(1);
    expect_out(8'h00, 0, 0, "R9 colliding edge dropped"); step(1);
    wr(8'h3F); step(3);
    expect_out(8'h00, 0, 0, "R9 dropped edge not recovered"); step(1);

    // R1: bit position of source 3
    src_in = 6'b001100; step(4);
    expect_out(8'h08, 1, 1, "R1 source 3 maps to bit 3"); step(1);

    step(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule